// File: doc/BRIEF.md
# Quad Programmable Clock Divider

This block derives four divided clocks from one reference clock. Each output has its own divide ratio, a phase offset in quarter-period steps and one of two waveform shapes. The phase offset is computed from the divide ratio, so the same two-bit phase select works for any ratio. In pulse shape the output is high for one reference cycle in each period. In square shape it is high for the first half of each phase-shifted period. All outputs are ordinary registered logic in the reference clock domain.

The whole setting is a single 49-bit word, applied as a parallel input. Whenever the word changes, every counter restarts from zero and the lock flag drops. The lock flag rises again once every enabled output has run through one complete period. Downstream logic can use it to wait until the divided clocks are running.

Top module: `clkdiv_quad`

## Requirements
- R1: Each output `i` has a counter that runs 0,1,…,D and wraps, where D is the output's 8-bit divide field, so its period is D+1 reference cycles (1 to 256). Outputs are registered: after the n-th rising edge following reset release (or following a restart), output `i` shows the waveform value for count (n-1) mod (D+1).
- R2: The 2-bit phase select sets the offset O with integer division: 0 gives 0, 1 gives D/4, 2 gives D/2, 3 gives D/2 + D/4.
- R3: With the duty bit at 0 (pulse shape), the output is high exactly when the count equals O, and low at every other count.
- R4: With the duty bit at 1 (square shape), the output is high when ((count − O) mod (D+1)) < (D+1)/2 (integer division), and low otherwise. When D = 0 the output is constantly high.
- R5: The configuration word has this layout. Bit 0 is the global enable. Output i uses bits [8i+8 : 8i+1] for its divide field, bits [2i+34 : 2i+33] for its phase select, bit 41+i for its enable and bit 45+i for its duty bit.
- R6: `locked` is 1 after edge n exactly when the global enable is 1 and n ≥ M, where M is the largest D+2 over the enabled outputs. M is 1 when no output is enabled.
- R7: An output that is disabled, or any output while the global enable is 0, holds its counter at zero and stays low. It does not delay `locked`. While the global enable is 0, `locked` stays 0.
- R8: When the configuration word differs from its value one cycle earlier, the next edge forces all outputs low and `locked` to 0, and counting restarts from zero (that edge counts as edge 0).
- R9: A synchronous active-high reset clears every counter and output and `locked`. Edge 1 is the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg | input | 49 | Configuration word (layout in R5) |
| clk_out | output | 4 | Divided clock outputs, bit i is output i |
| locked | output | 1 | High once every enabled output has completed a period |

## Verification
The hardest condition to reach is a lock flag that waits on the slowest enabled output. It must ignore a slow output that is disabled, and it must still come out right when the largest divide ratio, 255, sits next to a ratio of 0. The bench reaches this by mixing a divide-by-256 square output with a constant-high output and two mid-range ratios. It then repeats the check with a large ratio on a disabled output. A configuration change in the middle of a run, after lock, checks that the lock flag drops and the phase is restarted from the ports alone.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Quarter-period phase steps selected per output
  typedef enum logic [1:0] {
    PH_Q0 = 2'd0,
    PH_Q1 = 2'd1,
    PH_Q2 = 2'd2,
    PH_Q3 = 2'd3
  } phase_sel_e;

  // Waveform shape of one output
  typedef enum logic {
    SHAPE_PULSE  = 1'b0,
    SHAPE_SQUARE = 1'b1
  } shape_e;

  // Per-output fields besides the divider: phase (2), enable (1), duty (1)
  localparam int FIELD_EXTRA_W = 4;

endpackage

// File: rtl/clkdiv_cfg_decode.sv
module clkdiv_cfg_decode #(
  parameter int NUM_OUT = 4,
  parameter int DIV_W   = 8,
  localparam int CFG_W  = 1 + NUM_OUT * (DIV_W + clkdiv_pkg::FIELD_EXTRA_W)
) (
  input  logic [CFG_W-1:0]              cfg,
  output logic                          glob_en,
  output logic [NUM_OUT-1:0][DIV_W-1:0] div_val,
  output logic [NUM_OUT-1:0][1:0]       phase_sel,
  output logic [NUM_OUT-1:0]            out_en,
  output logic [NUM_OUT-1:0]            shape
);
  localparam int DIV_BASE = 1;
  localparam int PH_BASE  = DIV_BASE + NUM_OUT * DIV_W;
  localparam int EN_BASE  = PH_BASE + NUM_OUT * 2;
  localparam int SH_BASE  = EN_BASE + NUM_OUT;

  assign glob_en = cfg[0];

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_field
    assign div_val[i]   = cfg[DIV_BASE + i*DIV_W +: DIV_W];
    assign phase_sel[i] = cfg[PH_BASE + i*2 +: 2];
    assign out_en[i]    = cfg[EN_BASE + i];
    assign shape[i]     = cfg[SH_BASE + i];
  end

endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel
  import clkdiv_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  input  logic [1:0]       phase_sel,
  input  logic             shape,
  output logic             wave_q,
  output logic             lap_done
);
  localparam int W = DIV_W + 1;

  logic [DIV_W-1:0] cnt;
  logic [W-1:0]     period, half, offset, cnt_x, shifted;
  logic             wave_d;
  logic             at_top;

  assign at_top = (cnt == div_val);
  assign period = {1'b0, div_val} + W'(1);
  assign half   = period >> 1;
  assign cnt_x  = W'(cnt);

  always_comb begin
    unique case (phase_sel_e'(phase_sel))
      PH_Q0:   offset = '0;
      PH_Q1:   offset = W'(div_val >> 2);
      PH_Q2:   offset = W'(div_val >> 1);
      default: offset = W'(div_val >> 1) + W'(div_val >> 2);
    endcase
  end

  assign shifted = (cnt_x >= offset) ? (cnt_x - offset) : (cnt_x + period - offset);

  always_comb begin
    if (shape_e'(shape) == SHAPE_SQUARE) begin
      wave_d = (div_val == '0) ? 1'b1 : (shifted < half);
    end else begin
      wave_d = (cnt_x == offset);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt      <= '0;
      wave_q   <= 1'b0;
      lap_done <= 1'b0;
    end else begin
      cnt      <= at_top ? '0 : cnt + DIV_W'(1);
      wave_q   <= wave_d;
      lap_done <= lap_done | at_top;
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= div_val));

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!wave_q && cnt == '0 && !lap_done));

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    (wave_q && shape == 1'b0 && div_val != '0) |=> !wave_q);

endmodule

// File: rtl/clkdiv_lock.sv
module clkdiv_lock #(
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               glob_en,
  input  logic               restart,
  input  logic [NUM_OUT-1:0] out_en,
  input  logic [NUM_OUT-1:0] lap_done,
  output logic               locked
);
  logic all_ok;

  assign all_ok = &(lap_done | ~out_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
    end else begin
      locked <= glob_en && !restart && all_ok;
    end
  end

  // R8
  restart_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> !locked);

  // R6
  lock_needs_laps_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(&(lap_done | ~out_en)));

endmodule

// File: rtl/clkdiv_quad.sv
module clkdiv_quad #(
  parameter int NUM_OUT = 4,
  parameter int DIV_W   = 8,
  localparam int CFG_W  = 1 + NUM_OUT * (DIV_W + clkdiv_pkg::FIELD_EXTRA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CFG_W-1:0]   cfg,
  output logic [NUM_OUT-1:0] clk_out,
  output logic               locked
);
  logic [CFG_W-1:0]              cfg_q;
  logic                          restart;
  logic                          glob_en;
  logic [NUM_OUT-1:0][DIV_W-1:0] div_val;
  logic [NUM_OUT-1:0][1:0]       phase_sel;
  logic [NUM_OUT-1:0]            out_en;
  logic [NUM_OUT-1:0]            shape;
  logic [NUM_OUT-1:0]            lap_done;

  // Shadow copy of the word to detect any change
  always_ff @(posedge clk) begin
    cfg_q <= cfg;
  end

  assign restart = !rst && (cfg != cfg_q);

  clkdiv_cfg_decode #(.NUM_OUT(NUM_OUT), .DIV_W(DIV_W)) u_decode (
    .cfg       (cfg),
    .glob_en   (glob_en),
    .div_val   (div_val),
    .phase_sel (phase_sel),
    .out_en    (out_en),
    .shape     (shape)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chan
    clkdiv_channel #(.DIV_W(DIV_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .run       (glob_en && out_en[i] && !restart),
      .div_val   (div_val[i]),
      .phase_sel (phase_sel[i]),
      .shape     (shape[i]),
      .wave_q    (clk_out[i]),
      .lap_done  (lap_done[i])
    );
  end

  clkdiv_lock #(.NUM_OUT(NUM_OUT)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .glob_en  (glob_en),
    .restart  (restart),
    .out_en   (out_en),
    .lap_done (lap_done),
    .locked   (locked)
  );

  // R7
  glob_off_chk: assert property (@(posedge clk) disable iff (rst)
    !glob_en |=> (clk_out == '0 && !locked));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (clk_out == '0 && !locked));

endmodule

// File: tb/clkdiv_quad_bench.sv
module clkdiv_quad_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [48:0] cfg = '0;
  logic [3:0]  clk_out;
  logic        locked;
  int          checks = 0;
  int          failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdiv_quad u_clkdiv_quad (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg),
    .clk_out (clk_out),
    .locked  (locked)
  );

  function automatic logic [48:0] mk_cfg(input logic g, input logic [31:0] divs,
                                         input logic [7:0] phs, input logic [3:0] ens,
                                         input logic [3:0] dus);
    return {dus, ens, phs, divs, g};
  endfunction

  function automatic logic [3:0] model_out(input logic [48:0] c, input int e);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      int d, p, k, o, ph;
      d  = int'(c[1 + 8*i +: 8]);
      ph = int'(c[33 + 2*i +: 2]);
      p  = d + 1;
      k  = (e - 1) % p;
      case (ph)
        0: o = 0;
        1: o = d / 4;
        2: o = d / 2;
        default: o = d / 2 + d / 4;
      endcase
      if (!c[0] || !c[41 + i]) r[i] = 1'b0;
      else if (c[45 + i]) r[i] = (d == 0) ? 1'b1 : (((k - o + p) % p) < (p / 2));
      else r[i] = (k == o);
    end
    return r;
  endfunction

  function automatic logic model_lock(input logic [48:0] c, input int e);
    int m;
    m = 1;
    for (int i = 0; i < 4; i++)
      if (c[41 + i] && int'(c[1 + 8*i +: 8]) + 2 > m) m = int'(c[1 + 8*i +: 8]) + 2;
    return c[0] && (e >= m);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic start_reset(input logic [48:0] c);
    @(negedge clk);
    cfg = c;
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic watch(input int n, input string tag);
    for (int e = 1; e <= n; e++) begin
      @(posedge clk);
      @(negedge clk);
      chk(tag, {28'b0, clk_out}, {28'b0, model_out(cfg, e)});
      chk("R6", {31'b0, locked}, {31'b0, model_lock(cfg, e)});
    end
  endtask

  task automatic test_reset;
    @(negedge clk);
    rst = 1'b1;
    cfg = mk_cfg(1'b1, 32'h01010101, 8'h00, 4'hF, 4'hF);
    @(posedge clk);
    @(negedge clk);
    chk("R9 outputs in reset", {28'b0, clk_out}, 32'h0);
    chk("R9 locked in reset", {31'b0, locked}, 32'h0);
  endtask

  task automatic test_pulse;
    start_reset(mk_cfg(1'b1, {8'd10, 8'd7, 8'd4, 8'd3}, {2'd3, 2'd2, 2'd1, 2'd0}, 4'hF, 4'h0));
    watch(30, "R1 R2 R3 R5 pulse");
  endtask

  task automatic test_square;
    start_reset(mk_cfg(1'b1, {8'd255, 8'd8, 8'd5, 8'd0}, {2'd2, 2'd3, 2'd1, 2'd0}, 4'hF, 4'hF));
    watch(270, "R1 R2 R4 R5 square");
  endtask

  task automatic test_partial;
    start_reset(mk_cfg(1'b1, {8'd20, 8'd9, 8'd2, 8'd200}, {2'd1, 2'd0, 2'd2, 2'd0}, 4'b1010, 4'b0010));
    watch(40, "R7 disabled outputs");
  endtask

  task automatic test_global_off;
    start_reset(mk_cfg(1'b0, {8'd1, 8'd2, 8'd0, 8'd3}, 8'h00, 4'hF, 4'b0010));
    watch(20, "R7 global disable");
  endtask

  task automatic test_reconfig;
    start_reset(mk_cfg(1'b1, {8'd3, 8'd2, 8'd1, 8'd0}, 8'h00, 4'hF, 4'h0));
    watch(12, "R1 R3 before change");
    @(negedge clk);
    cfg = mk_cfg(1'b1, {8'd6, 8'd4, 8'd3, 8'd5}, {2'd1, 2'd2, 2'd3, 2'd1}, 4'hF, 4'b0101);
    @(posedge clk);
    @(negedge clk);
    chk("R8 outputs on change", {28'b0, clk_out}, 32'h0);
    chk("R8 locked on change", {31'b0, locked}, 32'h0);
    watch(20, "R8 after change");
  endtask

  task automatic test_reset_midrun;
    start_reset(mk_cfg(1'b1, {8'd4, 8'd4, 8'd4, 8'd4}, {2'd0, 2'd1, 2'd2, 2'd3}, 4'hF, 4'b1100));
    watch(10, "R2 before reset");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9 outputs after mid reset", {28'b0, clk_out}, 32'h0);
    chk("R9 locked after mid reset", {31'b0, locked}, 32'h0);
    rst = 1'b0;
    watch(15, "R9 after reset");
  endtask

  initial begin
    test_reset();
    test_pulse();
    test_square();
    test_partial();
    test_global_off();
    test_reconfig();
    test_reset_midrun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule